// File: doc/BRIEF.md
# SDRAM Command Sequencer

This block sits between a simple single-request port and the command pins of a four-bank synchronous DRAM. Each request carries a flat address, a read/write flag and a close flag. The block splits the address into bank, row and column. It then emits the shortest legal command sequence for that request. The sequence may contain PRECHARGE, ACTIVE and READ or WRITE, and NOP cycles fill every timing gap. All command pins come from registers that update on the rising clock edge.

A table holds one open-row entry for each bank. When a request hits the open row of its bank, the block skips activation. When the bank holds a different row, the block closes that row with an explicit PRECHARGE before it activates the new one. When the close flag is set, the column command carries the auto-precharge bit, and the bank is marked closed without any further command. Each bank has its own recovery timer. A bank that is closing therefore stalls only requests to that same bank, and traffic to the other three banks proceeds while the precharge completes.

Top module: `sdram_cmd_seq`

## Requirements
- R1: After reset the command pins show NOP and `req_ready` is 1.
- R2: The request address is split as column = bits [8:0], row = bits [21:9] and bank = bits [23:22]. An ACTIVE command carries the bank on `cmd_ba` and the row on `cmd_a`. When the bank is closed and its timer has expired, ACTIVE appears 2 cycles after the accepting edge.
- R3: A READ or WRITE follows its ACTIVE exactly T_RCD cycles later. It carries the column on `cmd_a[8:0]` and the close flag on `cmd_a[10]`, and `cmd_a[9]`, `cmd_a[12:11]` are 0.
- R4: The pin values {cs_n, ras_n, cas_n, we_n} are ACTIVE=0011, READ=0101, WRITE=0100, PRECHARGE=0010 and NOP=0111.
- R5: A request to the row already open in its bank issues no ACTIVE. Its READ/WRITE appears 2 cycles after the accepting edge.
- R6: A request to a bank with another row open issues PRECHARGE 2 cycles after acceptance, with `cmd_a[10]`=0 and that bank on `cmd_ba`. The ACTIVE follows T_RP cycles later.
- R7: A READ/WRITE with the close flag set leaves the bank closed, and no PRECHARGE is ever issued for it. The next ACTIVE to that bank comes no earlier than T_RP+BURST_LEN cycles after that READ/WRITE.
- R8: While one bank is closing, commands to the other banks are not delayed by that bank's recovery timer.
- R9: `req_ready` is 0 from the accepting edge until the cycle in which the READ/WRITE appears. A request presented while it is 0 is ignored and produces no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_close | input | 1 | Close the row with auto-precharge after this access |
| req_addr | input | 24 | Flat address {bank, row, column} |
| req_ready | output | 1 | Block idle; a request is accepted when valid and ready |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_ba | output | 2 | Bank address |
| cmd_a | output | 13 | Row / column / control address pins |

## Verification
The bench sweeps all four banks through three kinds of access: a closed-bank access, an open-row hit and a row conflict. For each request it predicts the exact cycle and pin values of every command from an arithmetic bank model. A design that dropped the open-row table would emit a needless ACTIVE on hits. A design that mishandled conflicts would skip the PRECHARGE or place ACTIVE before T_RP has elapsed. Requests to a bank that has just auto-precharged check that the design waits for the recovery window. Hits on other banks issued in that same window check that the design does not serialise every bank behind one shared timer. A request poked while the block is busy would show up as a stray command if the handshake leaked.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_ACT = 4'b0011,
    CMD_RD  = 4'b0101,
    CMD_WR  = 4'b0100,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEC,
    ST_PRE,
    ST_ACT,
    ST_WAIT,
    ST_RW
  } st_e;
endpackage

// File: rtl/sdram_addr_split.sv
module sdram_addr_split #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 9,
  localparam int ADDR_W = BANK_W + ROW_W + COL_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank,
  output logic [ROW_W-1:0]  row,
  output logic [COL_W-1:0]  col
);
  assign col  = addr[COL_W-1:0];
  assign row  = addr[COL_W +: ROW_W];
  assign bank = addr[ADDR_W-1 -: BANK_W];
endmodule

// File: rtl/sdram_bank_table.sv
module sdram_bank_table #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13,
  parameter int T_RP   = 2,
  parameter int T_AP   = 6,
  localparam int NB    = 1 << BANK_W,
  localparam int TMR_W = $clog2(T_AP + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BANK_W-1:0] q_bank,
  input  logic [ROW_W-1:0]  q_row,
  output logic              q_open,
  output logic              q_hit,
  output logic              q_free,
  input  logic              act_en,
  input  logic              pre_en,
  input  logic              rw_en,
  input  logic              ap_en
);
  logic [NB-1:0]            vld;
  logic [NB-1:0][ROW_W-1:0] rows;
  logic [NB-1:0]            tmr_zero;

  for (genvar i = 0; i < NB; i++) begin : g_bank
    logic             vld_r;
    logic [ROW_W-1:0] row_r;
    logic [TMR_W-1:0] tmr_r;
    wire              sel = (q_bank == BANK_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        vld_r <= 1'b0;
        tmr_r <= '0;
      end else begin
        if (act_en && sel) vld_r <= 1'b1;
        if ((pre_en || ap_en) && sel) begin
          vld_r <= 1'b0;
          tmr_r <= pre_en ? TMR_W'(T_RP - 1) : TMR_W'(T_AP - 1);
        end else if (tmr_r != '0) begin
          tmr_r <= tmr_r - 1'b1;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (act_en && sel) row_r <= q_row;
    end

    assign vld[i]      = vld_r;
    assign rows[i]     = row_r;
    assign tmr_zero[i] = (tmr_r == '0);
  end

  assign q_open = vld[q_bank];
  assign q_hit  = q_open && (rows[q_bank] == q_row);
  assign q_free = tmr_zero[q_bank];

  // column command only to an open, matching row
  assert_rw_on_open_row_R3: assert property (@(posedge clk) disable iff (rst)
    rw_en |-> q_hit);

  // a closing bank is marked closed on the next cycle
  assert_close_marks_bank_R7: assert property (@(posedge clk) disable iff (rst)
    (pre_en || ap_en) |=> !vld[$past(q_bank)]);
endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdram_seq_pkg::*;
#(
  parameter int BANK_W    = 2,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 9,
  parameter int A_W       = 13,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 2,
  parameter int BURST_LEN = 4,
  localparam int ADDR_W   = BANK_W + ROW_W + COL_W,
  localparam int T_AP     = T_RP + BURST_LEN,
  localparam int WCNT_W   = $clog2(T_RCD + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_close,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              cmd_cs_n,
  output logic              cmd_ras_n,
  output logic              cmd_cas_n,
  output logic              cmd_we_n,
  output logic [BANK_W-1:0] cmd_ba,
  output logic [A_W-1:0]    cmd_a
);
  st_e               st;
  cmd_e              cmd_q;
  logic [BANK_W-1:0] ba_q;
  logic [A_W-1:0]    a_q;
  logic [WCNT_W-1:0] wcnt;

  logic [BANK_W-1:0] d_bank, r_bank;
  logic [ROW_W-1:0]  d_row, r_row;
  logic [COL_W-1:0]  d_col, r_col;
  logic              r_wr, r_ap;
  logic              q_open, q_hit, q_free;
  logic              act_en, pre_en, rw_en, ap_en;

  sdram_addr_split #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_split (
    .addr(req_addr), .bank(d_bank), .row(d_row), .col(d_col)
  );

  assign act_en = (st == ST_ACT) && q_free;
  assign pre_en = (st == ST_PRE);
  assign rw_en  = (st == ST_RW);
  assign ap_en  = rw_en && r_ap;

  sdram_bank_table #(.BANK_W(BANK_W), .ROW_W(ROW_W), .T_RP(T_RP), .T_AP(T_AP)) u_banks (
    .clk(clk), .rst(rst), .q_bank(r_bank), .q_row(r_row),
    .q_open(q_open), .q_hit(q_hit), .q_free(q_free),
    .act_en(act_en), .pre_en(pre_en), .rw_en(rw_en), .ap_en(ap_en)
  );

  assign req_ready = (st == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      cmd_q  <= CMD_NOP;
      ba_q   <= '0;
      a_q    <= '0;
      wcnt   <= '0;
      r_bank <= '0;
      r_row  <= '0;
      r_col  <= '0;
      r_wr   <= 1'b0;
      r_ap   <= 1'b0;
    end else begin
      cmd_q <= CMD_NOP;
      case (st)
        ST_IDLE: if (req_valid) begin
          r_bank <= d_bank;
          r_row  <= d_row;
          r_col  <= d_col;
          r_wr   <= req_write;
          r_ap   <= req_close;
          st     <= ST_DEC;
        end
        ST_DEC: begin
          if (q_hit)       st <= ST_RW;
          else if (q_open) st <= ST_PRE;
          else             st <= ST_ACT;
        end
        ST_PRE: begin
          cmd_q <= CMD_PRE;
          ba_q  <= r_bank;
          a_q   <= '0;
          st    <= ST_ACT;
        end
        ST_ACT: if (q_free) begin
          cmd_q <= CMD_ACT;
          ba_q  <= r_bank;
          a_q   <= A_W'(r_row);
          wcnt  <= WCNT_W'(T_RCD - 1);
          st    <= ST_WAIT;
        end
        ST_WAIT: begin
          if (wcnt <= WCNT_W'(1)) st <= ST_RW;
          else                    wcnt <= wcnt - 1'b1;
        end
        ST_RW: begin
          cmd_q  <= r_wr ? CMD_WR : CMD_RD;
          ba_q   <= r_bank;
          a_q    <= A_W'(r_col);
          a_q[10] <= r_ap;
          st     <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign cmd_cs_n  = cmd_q[3];
  assign cmd_ras_n = cmd_q[2];
  assign cmd_cas_n = cmd_q[1];
  assign cmd_we_n  = cmd_q[0];
  assign cmd_ba    = ba_q;
  assign cmd_a     = a_q;

  assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  assert_gap_after_pre_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_PRE) |=> (cmd_q == CMD_NOP));

  assert_gap_after_act_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_ACT) |=> (cmd_q == CMD_NOP));
endmodule

// File: tb/sdram_cmd_seq_tb.sv
module sdram_cmd_seq_tb;
  localparam int T_RCD = 3;
  localparam int T_RP  = 2;
  localparam int BL    = 4;
  localparam int T_AP  = T_RP + BL;
  localparam logic [3:0] C_ACT = 4'b0011, C_RD = 4'b0101, C_WR = 4'b0100,
                         C_PRE = 4'b0010, C_NOP = 4'b0111;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_write = 0, req_close = 0;
  logic [23:0] req_addr = '0;
  logic req_ready, cs_n, ras_n, cas_n, we_n;
  logic [1:0] ba;
  logic [12:0] a;

  sdram_cmd_seq #(.T_RCD(T_RCD), .T_RP(T_RP), .BURST_LEN(BL)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_close(req_close), .req_addr(req_addr), .req_ready(req_ready),
    .cmd_cs_n(cs_n), .cmd_ras_n(ras_n), .cmd_cas_n(cas_n), .cmd_we_n(we_n),
    .cmd_ba(ba), .cmd_a(a)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  int cyc = 0;
  int lg_n = 0;
  int lg_cyc [256];
  logic [3:0]  lg_cmd [256];
  logic [1:0]  lg_ba [256];
  logic [12:0] lg_a [256];

  bit          m_open [4];
  int          m_row [4];
  int          m_free [4];

  always @(posedge clk) begin
    #1;
    cyc = cyc + 1;
    if ({cs_n, ras_n, cas_n, we_n} != C_NOP && lg_n < 256) begin
      lg_cyc[lg_n] = cyc;
      lg_cmd[lg_n] = {cs_n, ras_n, cas_n, we_n};
      lg_ba[lg_n]  = ba;
      lg_a[lg_n]   = a;
      lg_n = lg_n + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  task automatic op(input bit wr, input int b, input int row, input int col,
                    input bit ap, input bit poke, input string tag);
    int acc, start, n, t, act_t;
    int e_cyc [3];
    logic [3:0] e_cmd [3];
    int e_ba [3];
    int e_a [3];
    while (!req_ready) @(negedge clk);
    acc = cyc + 1;
    start = lg_n;
    req_valid = 1; req_write = wr; req_close = ap;
    req_addr = {b[1:0], row[12:0], col[8:0]};
    @(negedge clk);
    chk(req_ready == 0, "R9 ready low after accept", req_ready, 0);
    if (poke) begin
      req_addr = {b[1:0] ^ 2'b01, 13'h1abc, 9'h055};
      req_write = ~wr;
      @(negedge clk);
    end
    req_valid = 0;
    while (!req_ready) @(negedge clk);
    // arithmetic model
    n = 0;
    t = acc + 2;
    if (m_open[b] && m_row[b] == row) begin
      // hit
    end else begin
      if (m_open[b]) begin
        e_cyc[n] = t; e_cmd[n] = C_PRE; e_ba[n] = b; e_a[n] = 0; n++;
        act_t = t + T_RP;
      end else begin
        act_t = (m_free[b] > t) ? m_free[b] : t;
      end
      e_cyc[n] = act_t; e_cmd[n] = C_ACT; e_ba[n] = b; e_a[n] = row; n++;
      t = act_t + T_RCD;
    end
    e_cyc[n] = t; e_cmd[n] = wr ? C_WR : C_RD; e_ba[n] = b;
    e_a[n] = col | (ap ? 1024 : 0); n++;
    if (ap) begin m_open[b] = 0; m_free[b] = t + T_AP; end
    else begin m_open[b] = 1; m_row[b] = row; end
    chk(lg_n - start == n, {tag, " command count"}, lg_n - start, n);
    for (int i = 0; i < n && start + i < lg_n; i++) begin
      chk(lg_cyc[start+i] == e_cyc[i], {tag, " command cycle"}, lg_cyc[start+i], e_cyc[i]);
      chk(lg_cmd[start+i] == e_cmd[i], "R4 pin encoding", lg_cmd[start+i], e_cmd[i]);
      chk(lg_ba[start+i] == e_ba[i], {tag, " bank pins"}, lg_ba[start+i], e_ba[i]);
      chk(lg_a[start+i] == e_a[i], {tag, " address pins"}, lg_a[start+i], e_a[i]);
    end
  endtask

  initial begin
    int base;
    for (int i = 0; i < 4; i++) begin m_open[i] = 0; m_row[i] = 0; m_free[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    chk({cs_n, ras_n, cas_n, we_n} == C_NOP, "R1 reset command", {cs_n, ras_n, cas_n, we_n}, C_NOP);
    chk(req_ready == 1, "R1 reset ready", req_ready, 1);
    for (int b = 0; b < 4; b++) begin
      op(1, b, b * 37 + 5, b * 3 + 1, 0, 0, "R2 closed bank activate");
      op(0, b, b * 37 + 5, b * 3 + 100, 0, b == 1, "R5 open row hit");
      op(0, b, b * 37 + 1005, 511, 1, 0, "R6 row conflict");
      op(1, b, b * 37 + 1005, 0, 0, 0, "R7 access after auto-precharge");
    end
    // overlap: close bank 2, then hit bank 3 inside bank 2's recovery window
    op(0, 2, 2 * 37 + 1005, 7, 1, 0, "R7 hit with close");
    op(1, 3, 3 * 37 + 1005, 9, 1, 0, "R8 other bank during recovery");
    op(0, 0, 0 * 37 + 1005, 3, 0, 0, "R8 other bank during recovery");
    op(0, 2, 8191, 2, 0, 0, "R7 reopen after recovery");
    op(1, 2, 8191, 0, 1, 1, "R3 column command fields");
    // no stray command from the poked request
    base = lg_n;
    repeat (12) @(negedge clk);
    chk(lg_n == base, "R9 ignored busy request", lg_n - base, 0);
    finish_run();
  end
endmodule